// File: doc/BRIEF.md
# Pixel Word Transmit Queue with Request and Interrupt Logic

This block buffers 32-bit pixel words between a register write port and a downstream serial encoder. Software, or a DMA engine, writes words into a 32-entry first-in first-out store through a data selector of a small register port. The encoder pulls words out one at a time with a pop strobe and receives each word, with a valid pulse, on the cycle after the pop. The current number of stored words is driven on a dedicated output.

A single programmable trigger level decides when the queue asks for more data. The queue asks when its free space is at least that level. A DMA-enable bit chooses where the request goes: a DMA request line, or a sticky CPU-request flag that can raise an interrupt. The status register holds three sticky flags that software clears by writing ones: CPU request, transfer finished (set by a pulse from the encoder) and overflow (a write that arrived while the queue was full). The same register also reports the live fill level. Per-source enables and a global enable gate these flags onto one registered interrupt line.

Top module: `pix_txq`

## Requirements
- R1: A write with `reg_sel`=0 while the queue holds fewer than 32 words stores `reg_wdata`, and `fill_level` rises by one on the next clock edge. Words leave through `enc_data` in the order in which they were written.
- R2: A data write while the queue holds 32 words is discarded. `fill_level` stays 32, the word never reaches `enc_data`, and overflow flag bit 2 of the status register is set and stays set until cleared.
- R3: A pop while the queue is empty leaves `enc_valid` low on the following cycle and `fill_level` at 0.
- R4: When the DMA-enable bit is 0 and the free space (32 minus the fill level) is at least the trigger level, CPU-request flag bit 1 of the status register is set. It stays set until software clears it.
- R5: `dma_req` is high exactly when the DMA-enable bit is 1 and the free space is at least the trigger level, and low otherwise. It follows register changes within two cycles.
- R6: A one-cycle `done_pulse` sets transfer-finish flag bit 0 of the status register. The flag stays set until software clears it.
- R7: A write with `reg_sel`=3 clears each flag whose bit in `reg_wdata` is 1 and leaves the other flags unchanged. If a flag's set condition occurs in the same cycle, the flag stays set.
- R8: `irq` is, one cycle later, the global enable (bit 5 of the enable register, `reg_sel`=2) ANDed with the OR of three terms, each a flag ANDed with its own enable: overflow enable bit 2, CPU-request enable bit 1, transfer-finish enable bit 0.
- R9: Selector codes are 0 for data (reads as 0), 1 for DMA control, 2 for interrupt enables and 3 for status. The DMA control register holds DMA enable in bit 5 and the 5-bit trigger level in bits 4:0, and reads back only those bits. Status bits 15:10 give the fill level. `reg_rdata` shows the selected register one cycle after `reg_sel` is applied.
- R10: Reset empties the queue and clears the flags and all enables. It sets the DMA control register to DMA disabled with trigger level 16, and drives `irq`, `dma_req` and `enc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the selected register |
| enc_pop | input | 1 | Encoder takes one word |
| enc_data | output | 32 | Word popped on the previous cycle |
| enc_valid | output | 1 | `enc_data` holds a freshly popped word |
| done_pulse | input | 1 | Encoder reports that a transfer has finished |
| fill_level | output | 6 | Number of stored words |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those where a flag's set condition meets a clear from software, and those where the trigger test sits right at its limit. The stimulus reaches the first by pulsing `done_pulse` in the same cycle as a write-one-to-clear. Because the CPU-request condition re-asserts on its own, the stimulus clears that flag and reads it back after the queue has settled. A vector table reaches the limits by filling the queue to exactly the trigger boundary: free space equal to the trigger, one word short of it, the queue full, and trigger levels of 0 and 1. It then drains the queue to check word order.

// File: rtl/pix_txq_pkg.sv
package pix_txq_pkg;
  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_DMACTL = 2'd1,
    SEL_INTEN  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int BIT_DMA_EN = 5;
  localparam int BIT_GLB_EN = 5;
  localparam int BIT_OVF    = 2;
  localparam int BIT_CPU    = 1;
  localparam int BIT_FIN    = 0;
  localparam int LVL_LSB    = 10;
endpackage

// File: rtl/pix_txq_store.sv
module pix_txq_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pop_ok;
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pix_txq_trig.sv
module pix_txq_trig #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] trig,
  input  logic          dma_en,
  output logic          space_ok,
  output logic          dma_req
);
  logic [CW-1:0] free;

  assign free     = CW'(DEPTH) - count;
  assign space_ok = (CW'(trig) <= free);

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= dma_en && space_ok;
  end
endmodule

// File: rtl/pix_txq_regs.sv
module pix_txq_regs
  import pix_txq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int RW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [5:0]    wbits,
  input  logic [CW-1:0] count,
  input  logic          space_ok,
  input  logic          push_drop,
  input  logic          done_pulse,
  output logic [RW-1:0] rdata,
  output logic          irq,
  output logic          dma_en,
  output logic [AW-1:0] trig,
  output logic          glb_en,
  output logic          fin_flag,
  output logic          cpu_flag,
  output logic          ovf_flag
);
  logic       en_ovf, en_cpu, en_fin;
  logic       wr_dma, wr_ien, wr_sts;
  logic [RW-1:0] sts_val, dma_val, ien_val;

  assign wr_dma = wr && (sel == SEL_DMACTL);
  assign wr_ien = wr && (sel == SEL_INTEN);
  assign wr_sts = wr && (sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en <= 1'b0;
      trig   <= AW'(DEPTH / 2);
      glb_en <= 1'b0;
      en_ovf <= 1'b0;
      en_cpu <= 1'b0;
      en_fin <= 1'b0;
    end else begin
      if (wr_dma) begin
        dma_en <= wbits[BIT_DMA_EN];
        trig   <= wbits[AW-1:0];
      end
      if (wr_ien) begin
        glb_en <= wbits[BIT_GLB_EN];
        en_ovf <= wbits[BIT_OVF];
        en_cpu <= wbits[BIT_CPU];
        en_fin <= wbits[BIT_FIN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_flag <= 1'b0;
      cpu_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (done_pulse)                    fin_flag <= 1'b1;
      else if (wr_sts && wbits[BIT_FIN]) fin_flag <= 1'b0;
      if (space_ok && !dma_en)           cpu_flag <= 1'b1;
      else if (wr_sts && wbits[BIT_CPU]) cpu_flag <= 1'b0;
      if (push_drop)                     ovf_flag <= 1'b1;
      else if (wr_sts && wbits[BIT_OVF]) ovf_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= glb_en && ((ovf_flag && en_ovf) || (cpu_flag && en_cpu) ||
                               (fin_flag && en_fin));
  end

  always_comb begin
    sts_val = '0;
    sts_val[LVL_LSB +: CW] = count;
    sts_val[BIT_OVF] = ovf_flag;
    sts_val[BIT_CPU] = cpu_flag;
    sts_val[BIT_FIN] = fin_flag;
    dma_val = '0;
    dma_val[BIT_DMA_EN] = dma_en;
    dma_val[AW-1:0] = trig;
    ien_val = '0;
    ien_val[BIT_GLB_EN] = glb_en;
    ien_val[BIT_OVF] = en_ovf;
    ien_val[BIT_CPU] = en_cpu;
    ien_val[BIT_FIN] = en_fin;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (sel)
        SEL_DMACTL: rdata <= dma_val;
        SEL_INTEN:  rdata <= ien_val;
        SEL_STATUS: rdata <= sts_val;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pix_txq.sv
module pix_txq #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          enc_pop,
  output logic [DW-1:0] enc_data,
  output logic          enc_valid,
  input  logic          done_pulse,
  output logic [CW-1:0] fill_level,
  output logic          dma_req,
  output logic          irq
);
  logic          push, push_drop, space_ok;
  logic          dma_en, glb_en, fin_flag, cpu_flag, ovf_flag;
  logic [AW-1:0] trig;

  assign push = reg_wr && (reg_sel == pix_txq_pkg::SEL_DATA);

  pix_txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .wdata(reg_wdata), .pop(enc_pop),
    .rdata(enc_data), .rvalid(enc_valid), .count(fill_level), .drop(push_drop)
  );

  pix_txq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst(rst), .count(fill_level), .trig(trig), .dma_en(dma_en),
    .space_ok(space_ok), .dma_req(dma_req)
  );

  pix_txq_regs #(.DEPTH(DEPTH), .RW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wbits(reg_wdata[5:0]),
    .count(fill_level), .space_ok(space_ok), .push_drop(push_drop),
    .done_pulse(done_pulse), .rdata(reg_rdata), .irq(irq), .dma_en(dma_en),
    .trig(trig), .glb_en(glb_en), .fin_flag(fin_flag), .cpu_flag(cpu_flag),
    .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/pix_txq_chk.sv
module pix_txq_chk #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic          w1c_ovf,
  input logic          enc_pop,
  input logic          enc_valid,
  input logic          done_pulse,
  input logic [CW-1:0] fill_level,
  input logic          dma_req,
  input logic          irq,
  input logic [AW-1:0] trig,
  input logic          glb_en,
  input logic          fin_flag,
  input logic          ovf_flag
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill_level <= CW'(DEPTH));

  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd0 && fill_level == CW'(DEPTH) && !enc_pop)
    |=> (fill_level == CW'(DEPTH) && ovf_flag));

  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(reg_wr && reg_sel == 2'd3 && w1c_ovf)) |=> ovf_flag);

  p_empty_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (enc_pop && fill_level == '0) |=> !enc_valid);

  p_dma_space_r5: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (int'($past(trig)) + int'($past(fill_level)) <= DEPTH));

  p_fin_set_r6: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> fin_flag);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en) |-> !irq);
endmodule

bind pix_txq pix_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .w1c_ovf(reg_wdata[2]), .enc_pop(enc_pop), .enc_valid(enc_valid),
  .done_pulse(done_pulse), .fill_level(fill_level), .dma_req(dma_req),
  .irq(irq), .trig(trig), .glb_en(glb_en), .fin_flag(fin_flag),
  .ovf_flag(ovf_flag)
);

// File: tb/pix_txq_bench.sv
module pix_txq_bench;
  localparam int QD = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        enc_pop = 1'b0;
  logic [31:0] enc_data;
  logic        enc_valid;
  logic        done_pulse = 1'b0;
  logic [5:0]  fill_level;
  logic        dma_req;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model_q[$];

  always #5 clk = ~clk;

  pix_txq u_pix_txq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enc_pop(enc_pop),
    .enc_data(enc_data), .enc_valid(enc_valid), .done_pulse(done_pulse),
    .fill_level(fill_level), .dma_req(dma_req), .irq(irq)
  );

  // {pushes[5:0], trigger[4:0], dma_en, exp_cpu_flag, exp_dma_req}
  localparam logic [13:0] VEC [9] = '{
    {6'd0,  5'd16, 1'b0, 1'b1, 1'b0},
    {6'd16, 5'd16, 1'b0, 1'b1, 1'b0},
    {6'd17, 5'd16, 1'b0, 1'b0, 1'b0},
    {6'd32, 5'd16, 1'b0, 1'b0, 1'b0},
    {6'd10, 5'd16, 1'b1, 1'b0, 1'b1},
    {6'd17, 5'd16, 1'b1, 1'b0, 1'b0},
    {6'd31, 5'd1,  1'b1, 1'b0, 1'b1},
    {6'd32, 5'd0,  1'b1, 1'b0, 1'b1},
    {6'd20, 5'd12, 1'b0, 1'b1, 1'b0}
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [31:0] d);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel;
    tick();
    v = reg_rdata;
  endtask

  task automatic push_n(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      wr_reg(2'd0, base + i);
      if (model_q.size() < QD) model_q.push_back(base + i);
    end
  endtask

  task automatic drain(string req);
    int errs = 0;
    logic [31:0] exp;
    while (fill_level != 0) begin
      enc_pop = 1'b1;
      tick();
      enc_pop = 1'b0;
      exp = (model_q.size() > 0) ? model_q.pop_front() : 32'hDEAD_BEEF;
      if (!enc_valid || enc_data !== exp) errs++;
    end
    chk(req, errs, 0);
    chk(req, model_q.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(3);
    // R10 reset state at the ports
    chk("R10 fill", fill_level, 0);
    chk("R10 irq", irq, 0);
    chk("R10 dma_req", dma_req, 0);
    chk("R10 enc_valid", enc_valid, 0);
    rst = 1'b0;
    tick(2);
    rd_reg(2'd1, v);
    chk("R10 dmactl reset", v, 32'h10);
    rd_reg(2'd2, v);
    chk("R10 inten reset", v, 32'h0);
    rd_reg(2'd3, v);
    chk("R10 status reset", v & 32'h0000_FC05, 32'h0);

    // R3 pop on empty
    enc_pop = 1'b1;
    tick();
    enc_pop = 1'b0;
    chk("R3 valid", enc_valid, 0);
    chk("R3 fill", fill_level, 0);

    // Vector table: trigger boundaries (R4, R5), fill field (R9), order (R1)
    for (int k = 0; k < 9; k++) begin
      logic [5:0] n;
      n = VEC[k][13:8];
      wr_reg(2'd1, {26'd0, VEC[k][2], VEC[k][7:3]});
      push_n(int'(n), 32'hA000_0000 + k * 64);
      tick(3);
      chk("R1 fill_level", fill_level, n);
      wr_reg(2'd3, 32'h7);
      tick(2);
      rd_reg(2'd3, v);
      chk("R9 status fill field", v[15:10], n);
      chk("R4 cpu flag", v[1], VEC[k][1]);
      chk("R5 dma_req", dma_req, VEC[k][0]);
      drain("R1 order");
    end
    wr_reg(2'd1, 32'h10);

    // R2 overflow: 33 writes, last dropped
    push_n(33, 32'h5500_0000);
    tick(2);
    rd_reg(2'd3, v);
    chk("R2 ovf flag", v[2], 1);
    chk("R2 fill stays full", v[15:10], 32);
    wr_reg(2'd3, 32'h1);
    tick();
    rd_reg(2'd3, v);
    chk("R7 ovf kept on zero bit", v[2], 1);
    wr_reg(2'd3, 32'h4);
    tick();
    rd_reg(2'd3, v);
    chk("R7 ovf cleared", v[2], 0);
    drain("R2 dropped word absent");

    // R6 / R8 finish flag and interrupt gating
    wr_reg(2'd2, 32'h21);
    done_pulse = 1'b1;
    tick();
    done_pulse = 1'b0;
    tick(2);
    chk("R8 irq on finish", irq, 1);
    tick(5);
    rd_reg(2'd3, v);
    chk("R6 finish sticky", v[0], 1);
    wr_reg(2'd2, 32'h01);
    tick(2);
    chk("R8 global gate", irq, 0);
    wr_reg(2'd2, 32'h21);
    tick(2);
    chk("R8 irq regained", irq, 1);
    wr_reg(2'd3, 32'h1);
    tick(2);
    chk("R7 irq after clear", irq, 0);
    rd_reg(2'd3, v);
    chk("R7 finish cleared", v[0], 0);

    // R7 set wins over clear in the same cycle
    done_pulse = 1'b1;
    wr_reg(2'd3, 32'h1);
    done_pulse = 1'b0;
    tick();
    rd_reg(2'd3, v);
    chk("R7 set wins", v[0], 1);
    wr_reg(2'd3, 32'h1);

    // R8 CPU request source (empty queue, trigger 16, DMA off)
    wr_reg(2'd2, 32'h22);
    tick(3);
    chk("R8 irq on cpu request", irq, 1);
    wr_reg(2'd2, 32'h20);
    tick(2);
    chk("R8 source enable gate", irq, 0);

    // R9 DMA control readback
    wr_reg(2'd1, 32'h2A);
    rd_reg(2'd1, v);
    chk("R9 dmactl readback", v, 32'h2A);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, v);
    chk("R9 dmactl masked", v, 32'h3F);
    rd_reg(2'd0, v);
    chk("R9 data reads zero", v, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule